// File: doc/BRIEF.md
# Ripple-Carry Integer ALU with Zero and Overflow Flags

This block is the combinational arithmetic logic unit of a small RISC integer datapath. It takes two operands and a 4-bit operation code and returns a result word, a zero flag and a signed-overflow flag in the same cycle. Six operations share one adder path: AND, OR, NOR, add, subtract and signed set-on-less-than.

The operation code is a set of control fields rather than an opaque number. One bit inverts operand A, one bit inverts operand B and also supplies the carry into bit 0, and the low two bits pick the output of each bit slice. The adder is built as a chain of one-bit slices with an explicit carry between them. Because the carry into the top bit is a visible net, overflow is formed from that carry and the carry out of the top bit. Sign or zero extension of immediates, shifts, multiply and divide are handled elsewhere in the datapath.

Top module: `alu_rc`

## Requirements
- R1: The operation code decodes as fields: bit 3 inverts every bit of A, bit 2 inverts every bit of B and sets the carry into bit 0, and bits 1:0 choose the slice output (00 bitwise AND, 01 bitwise OR, 10 adder sum, 11 less-than value).
- R2: Code 0000 returns A AND B and code 0001 returns A OR B, bit by bit with no interaction between bit positions.
- R3: Code 1100 returns A NOR B, produced as (NOT A) AND (NOT B).
- R4: Code 0010 returns A plus B modulo 2^WIDTH.
- R5: Code 0110 returns A minus B modulo 2^WIDTH, formed by adding the bitwise inverse of B with a carry-in of 1.
- R6: Code 0111 returns 1 in bit 0 when A is less than B as signed numbers and 0 otherwise, including when A minus B overflows; every bit above bit 0 is 0.
- R7: The zero flag is 1 exactly when every bit of the result is 0, for every operation.
- R8: For add and subtract, the overflow flag is 1 exactly when the true signed result lies outside the range of a WIDTH-bit two's-complement number; it equals the carry into the top bit XOR the carry out of it.
- R9: Adding operands whose sign bits differ, or subtracting operands whose sign bits match, never sets the overflow flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op | input | 4 | Operation code: A-invert, B-invert, 2-bit slice output select |
| opa | input | WIDTH | First operand |
| opb | input | WIDTH | Second operand |
| res | output | WIDTH | Result word |
| zero | output | 1 | High when the result is all zeros |
| ovf | output | 1 | Signed overflow of the adder path (meaningful for add and subtract) |

## Verification
Immediate assertions inside the design check on every input change that add, subtract and NOR results match the arithmetic on the ports, that set-on-less-than leaves only the signed comparison in bit 0, that a subtraction of equal operands raises the zero flag, and that the overflow flag obeys the sign rules for add and for subtract. The bench sweeps every operand pair and every defined code on a 4-bit instance, which alone shows the AND and OR paths, the zero flag on all operations and set-on-less-than across the overflowing corner pairs. A 32-bit instance then takes directed corner cases at the extremes of the signed range, where a carry must ripple across all slices.

// File: rtl/alu_rc.sv
module alu_rc #(
  parameter int WIDTH = 32
) (
  input  logic [3:0]       op,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  output logic [WIDTH-1:0] res,
  output logic             zero,
  output logic             ovf
);

  localparam int MSB = WIDTH - 1;

  logic             inv_a;
  logic             inv_b;
  logic [1:0]       sel;
  logic [WIDTH:0]   cy;
  logic [WIDTH-1:0] sum;
  logic             less;

  assign inv_a = op[3];
  assign inv_b = op[2];
  assign sel   = op[1:0];
  assign cy[0] = inv_b;

  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    logic xa, xb, hp, lt_in;
    assign xa        = opa[i] ^ inv_a;
    assign xb        = opb[i] ^ inv_b;
    assign hp        = xa ^ xb;
    assign sum[i]    = hp ^ cy[i];
    assign cy[i+1]   = (xa & xb) | (hp & cy[i]);
    if (i == 0) begin : g_lsb
      assign lt_in = less;
    end else begin : g_rest
      assign lt_in = 1'b0;
    end
    assign res[i] = (sel == 2'b00) ? (xa & xb) :
                    (sel == 2'b01) ? (xa | xb) :
                    (sel == 2'b10) ? sum[i]    : lt_in;
  end

  assign ovf  = cy[WIDTH] ^ cy[MSB];
  assign less = sum[MSB] ^ ovf;
  assign zero = ~|res;

  always_comb begin
    if (op == 4'b0010) begin
      // R4
      add_sum_chk: assert (res == opa + opb) else $error("add result mismatch");
      // R9
      add_mixed_sign_chk: assert (!(opa[MSB] != opb[MSB] && ovf)) else $error("add overflow on mixed signs");
      // R8
      add_ovf_chk: assert (ovf == (opa[MSB] == opb[MSB] && res[MSB] != opa[MSB])) else $error("add overflow flag wrong");
    end
    if (op == 4'b0110) begin
      // R5
      sub_diff_chk: assert (res == opa - opb) else $error("sub result mismatch");
      // R9
      sub_same_sign_chk: assert (!(opa[MSB] == opb[MSB] && ovf)) else $error("sub overflow on equal signs");
      // R7
      sub_zero_chk: assert (zero == (opa == opb)) else $error("zero flag wrong on sub");
    end
    if (op == 4'b0111) begin
      // R6
      slt_value_chk: assert (res == {{MSB{1'b0}}, ($signed(opa) < $signed(opb))}) else $error("slt result wrong");
    end
    if (op == 4'b1100) begin
      // R3
      nor_value_chk: assert (res == ~(opa | opb)) else $error("nor result wrong");
    end
  end

endmodule

// File: tb/alu_rc_tb.sv
module alu_rc_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [3:0]  op_s, op_w;
  logic [3:0]  a_s, b_s;
  logic [31:0] a_w, b_w;
  logic [3:0]  res_s;
  logic [31:0] res_w;
  logic zero_s, ovf_s, zero_w, ovf_w;

  alu_rc #(.WIDTH(4)) u_dut (
    .op(op_s), .opa(a_s), .opb(b_s), .res(res_s), .zero(zero_s), .ovf(ovf_s)
  );

  alu_rc #(.WIDTH(32)) u_dut_w (
    .op(op_w), .opa(a_w), .opb(b_w), .res(res_w), .zero(zero_w), .ovf(ovf_w)
  );

  function automatic longint sx(input longint v, input int w);
    return (v >= (longint'(1) << (w - 1))) ? v - (longint'(1) << w) : v;
  endfunction

  // expected result/ovf per requirement text, from operand values
  task automatic model(input logic [3:0] op, input longint a, input longint b, input int w,
                       output longint r, output bit ov, output bit ov_valid);
    longint m = (longint'(1) << w) - 1;
    longint lo = -(longint'(1) << (w - 1));
    longint hi = (longint'(1) << (w - 1)) - 1;
    longint t;
    ov = 1'b0; ov_valid = 1'b0; r = 0;
    case (op)
      4'b0000: r = a & b;
      4'b0001: r = a | b;
      4'b1100: r = (~(a | b)) & m;
      4'b0010: begin
        t = sx(a, w) + sx(b, w); r = (a + b) & m; ov = (t < lo) || (t > hi); ov_valid = 1'b1;
      end
      4'b0110: begin
        t = sx(a, w) - sx(b, w); r = (a - b) & m; ov = (t < lo) || (t > hi); ov_valid = 1'b1;
      end
      4'b0111: r = (sx(a, w) < sx(b, w)) ? 1 : 0;
      default: r = 0;
    endcase
  endtask

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'b0000: return "R2 and";
      4'b0001: return "R2 or";
      4'b1100: return "R3 nor";
      4'b0010: return "R4/R8 add";
      4'b0110: return "R5/R8 sub";
      4'b0111: return "R6 slt";
      default: return "R1";
    endcase
  endfunction

  task automatic run_small(input logic [3:0] op, input logic [3:0] a, input logic [3:0] b);
    longint r; bit ov, ovv;
    @(posedge clk); #1;
    op_s = op; a_s = a; b_s = b;
    #1;
    model(op, longint'(a), longint'(b), 4, r, ov, ovv);
    total++;
    // R7 zero flag checked with every vector
    if (res_s !== r[3:0] || zero_s !== (r == 0) || (ovv && ovf_s !== ov)) begin
      bad++;
      $display("FAIL %s R7 w4 a=%h b=%h: got res=%h z=%b v=%b exp res=%h z=%b v=%b",
               tag_of(op), a, b, res_s, zero_s, ovf_s, r[3:0], (r == 0), ov);
    end
  endtask

  task automatic run_wide(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                          input string why);
    longint r; bit ov, ovv;
    @(posedge clk); #1;
    op_w = op; a_w = a; b_w = b;
    #1;
    model(op, longint'(a), longint'(b), 32, r, ov, ovv);
    total++;
    if (res_w !== r[31:0] || zero_w !== (r == 0) || (ovv && ovf_w !== ov)) begin
      bad++;
      $display("FAIL %s %s a=%h b=%h: got res=%h z=%b v=%b exp res=%h z=%b v=%b",
               tag_of(op), why, a, b, res_w, zero_w, ovf_w, r[31:0], (r == 0), ov);
    end
  endtask

  initial begin
    op_s = 4'b0000; a_s = '0; b_s = '0;
    op_w = 4'b0000; a_w = '0; b_w = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // reset-time state: AND of zeros gives zero result, zero flag set (R2, R7)
    total++;
    if (res_w !== 32'h0 || zero_w !== 1'b1) begin
      bad++;
      $display("FAIL R7 idle: got res=%h z=%b exp res=0 z=1", res_w, zero_w);
    end
    // R1: exhaustive sweep of all defined codes on the 4-bit instance
    for (int k = 0; k < 6; k++) begin
      logic [3:0] oc;
      case (k)
        0: oc = 4'b0000; 1: oc = 4'b0001; 2: oc = 4'b1100;
        3: oc = 4'b0010; 4: oc = 4'b0110; default: oc = 4'b0111;
      endcase
      for (int a = 0; a < 16; a++)
        for (int b = 0; b < 16; b++)
          run_small(oc, a[3:0], b[3:0]);
    end
    // R8: carry ripples through all 32 slices
    run_wide(4'b0010, 32'h7fff_ffff, 32'h0000_0001, "R8 max+1");
    run_wide(4'b0010, 32'h8000_0000, 32'h8000_0000, "R8 min+min");
    run_wide(4'b0010, 32'hffff_ffff, 32'h0000_0001, "R9 -1+1");
    run_wide(4'b0110, 32'h8000_0000, 32'h0000_0001, "R8 min-1");
    run_wide(4'b0110, 32'h7fff_ffff, 32'hffff_ffff, "R8 max-(-1)");
    run_wide(4'b0110, 32'h1234_5678, 32'h1234_5678, "R7 equal");
    run_wide(4'b0110, 32'hffff_ffff, 32'h8000_0000, "R9 same sign");
    // R6 with overflowing subtraction
    run_wide(4'b0111, 32'h8000_0000, 32'h0000_0001, "R6 min<1");
    run_wide(4'b0111, 32'h7fff_ffff, 32'h8000_0000, "R6 max<min");
    run_wide(4'b0111, 32'h0000_0005, 32'h0000_0005, "R6 equal");
    run_wide(4'b1100, 32'h0f0f_00ff, 32'h00ff_0f0f, "R3 pattern");
    run_wide(4'b0000, 32'hdead_beef, 32'h0ff0_f00f, "R2 pattern");
    run_wide(4'b0001, 32'h0000_0000, 32'h0000_0000, "R2 zero");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule